// File: doc/BRIEF.md
# Sparse-Space Single-Longword Packetizer

This block sits between a CPU-side request port and a downstream I/O link. Each sparse-space request arrives as a 32-byte data block with one mask bit per longword, an address and a set of length codes. The block turns the request into one packet that carries a single longword. For a write, the block chooses the data longword from the mask bits. Only the odd longword positions (1, 3, 5 and 7, counting from 1) can carry sparse data. The block then derives the two lane bits that go into the packet. For a read, the lane bits come from the address and the packet carries no data. When the read response arrives, the returned longword is placed back into its lane of a 32-byte block.

Before any packet goes out, the block settles the transfer length and checks it. The length is the largest length code present in the request. It must be legal at the block offset given by address bits <6:5>. If the length, the offset or the write mask is wrong, the request is refused with a one-cycle error pulse and no packet is sent.

A four-state machine controls the block:
- S_IDLE accepts a request. A legal request moves to S_SEND; an illegal one pulses the error output and stays in S_IDLE.
- S_SEND holds the packet until the link accepts it. A write then returns to S_IDLE; a read moves to S_WAIT.
- S_WAIT moves to S_RET when the response is valid.
- S_RET presents the aligned data for one cycle and returns to S_IDLE.

Top module: `sp_packetizer`

## Requirements
- R1: While reset is held, and in the first cycle after it, req_ready is 1 and pkt_valid, ret_valid and err are 0.
- R2: A write sends a packet with pkt_write=1. Mask bit 0, 2, 4 or 6 gives pkt_sel 0, 1, 2 or 3. pkt_data is longword index 2*pkt_sel of req_data, where longword i is bits [32i+31:32i]. The address lane bits req_addr[4:3] have no effect on a write.
- R3: A write is refused if its mask does not have exactly one set bit, or if that bit is odd (1, 3, 5 or 7). A refused write gives err=1 for exactly the cycle after acceptance and no packet.
- R4: req_len_set bit 0 means byte, bit 1 word, bit 2 tribyte, bit 3 longword and bit 4 quadword. The highest set bit is used, and pkt_len carries its code 0 to 4. An empty set is refused with err.
- R5: The offset is req_addr[6:5]. Byte is legal at offsets 0, 1, 2 and 3; word at 0 and 2; tribyte at 0 and 1; longword only at 0; quadword only at 3. An illegal pair gives err for one cycle and no packet.
- R6: A read sends a packet with pkt_write=0, pkt_sel=req_addr[4:3] and pkt_data=0.
- R7: A response sampled while a read waits gives ret_valid=1 for exactly the next cycle. In that cycle ret_data holds rsp_data in longword 2*pkt_sel and zero in every other longword.
- R8: The packet appears in the cycle after acceptance. While pkt_valid=1 and pkt_ready=0, every packet field holds steady and req_ready=0. A request offered while busy is ignored.
- R9: pkt_addr equals req_addr[31:5], which is the 32-byte-aligned block address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and taking a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 29 | Address bits [31:3] |
| req_mask | input | 8 | One mask bit per longword |
| req_len_set | input | 5 | Length codes present (bit 0 byte to bit 4 quadword) |
| req_data | input | 256 | 32-byte data block |
| pkt_valid | output | 1 | Packet offered downstream |
| pkt_ready | input | 1 | Downstream accepts packet |
| pkt_write | output | 1 | Packet direction |
| pkt_addr | output | 27 | Block-aligned address |
| pkt_sel | output | 2 | Lane bits <4:3> |
| pkt_len | output | 3 | Length code |
| pkt_data | output | 32 | Single longword of write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read response longword |
| ret_valid | output | 1 | Aligned return block valid |
| ret_data | output | 256 | Returned block with data in its lane |
| err | output | 1 | Request refused pulse |

## Verification
The assertions assume a response arrives only while a read is waiting, and that the downstream side does not ask for a packet to be dropped. The stimulus offers responses only after a read packet has been taken. The stimulus drops req_valid before it releases a stalled packet, so the only request that gets accepted is the one the test means. The stimulus changes inputs only on the falling clock edge, so every accepted request is sampled whole on one rising edge.

// File: rtl/sp_pkg.sv
package sp_pkg;
    // Transfer length codes, ordered by size so that "largest" means highest code
    typedef enum logic [2:0] {
        LEN_BYTE = 3'd0,
        LEN_WORD = 3'd1,
        LEN_TRI  = 3'd2,
        LEN_LONG = 3'd3,
        LEN_QUAD = 3'd4
    } sp_len_e;

    localparam int NLEN = 5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SEND,
        S_WAIT,
        S_RET
    } sp_state_e;
endpackage

// File: rtl/sp_len_check.sv
module sp_len_check
    import sp_pkg::*;
(
    input  logic [NLEN-1:0] len_set,
    input  logic [1:0]      offset,
    output sp_len_e         len,
    output logic            legal
);
    logic       found;
    logic [3:0] allowed;

    // Largest requested length wins: scan from the top code down
    always_comb begin
        found = 1'b0;
        len   = LEN_BYTE;
        for (int i = NLEN - 1; i >= 0; i--) begin
            if (!found && len_set[i]) begin
                found = 1'b1;
                len   = sp_len_e'(3'(i));
            end
        end
    end

    // Offsets (address bits <6:5>) at which each length may be used
    always_comb begin
        unique case (len)
            LEN_BYTE: allowed = 4'b1111;
            LEN_WORD: allowed = 4'b0101;
            LEN_TRI:  allowed = 4'b0011;
            LEN_LONG: allowed = 4'b0001;
            LEN_QUAD: allowed = 4'b1000;
            default:  allowed = 4'b0000;
        endcase
        legal = found && allowed[offset];
    end
endmodule

// File: rtl/sp_lane_pick.sv
module sp_lane_pick #(
    parameter int LW_W = 32,
    parameter int NLW  = 8,
    localparam int NSEL  = NLW / 2,
    localparam int SEL_W = $clog2(NSEL)
) (
    input  logic [NLW-1:0]      mask,
    input  logic [NLW*LW_W-1:0] data,
    output logic [SEL_W-1:0]    sel,
    output logic                mask_ok,
    output logic [LW_W-1:0]     lw
);
    logic [NSEL-1:0] even_bits;
    logic [NSEL-1:0] odd_bits;
    logic            found;

    // Split the mask into the data-bearing (odd-position) lanes and the rest
    for (genvar k = 0; k < NSEL; k++) begin : g_split
        assign even_bits[k] = mask[2*k];
        assign odd_bits[k]  = mask[2*k+1];
    end

    // Lowest data-bearing mask bit gives the lane
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < NSEL; k++) begin
            if (!found && even_bits[k]) begin
                found = 1'b1;
                sel   = SEL_W'(k);
            end
        end
    end

    assign mask_ok = ($countones(even_bits) == 1) && (odd_bits == '0);

    always_comb begin
        lw = data[(2 * int'(sel)) * LW_W +: LW_W];
    end
endmodule

// File: rtl/sp_ret_align.sv
module sp_ret_align #(
    parameter int LW_W = 32,
    parameter int NLW  = 8,
    localparam int SEL_W = $clog2(NLW / 2)
) (
    input  logic [SEL_W-1:0]    sel,
    input  logic [LW_W-1:0]     word,
    output logic [NLW*LW_W-1:0] blk
);
    for (genvar k = 0; k < NLW; k++) begin : g_lane
        if (k % 2 == 0) begin : g_data
            assign blk[k*LW_W +: LW_W] = (sel == SEL_W'(k / 2)) ? word : '0;
        end else begin : g_zero
            assign blk[k*LW_W +: LW_W] = '0;
        end
    end
endmodule

// File: rtl/sp_packetizer.sv
module sp_packetizer
    import sp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LW_W   = 32,
    parameter int NLW    = 8,
    localparam int BLOCK_W  = LW_W * NLW,
    localparam int SEL_W    = $clog2(NLW / 2),
    localparam int PAIR_LSB = $clog2(LW_W / 8) + 1,
    localparam int BLK_LSB  = $clog2(BLOCK_W / 8)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:PAIR_LSB]  req_addr,
    input  logic [NLW-1:0]            req_mask,
    input  logic [NLEN-1:0]           req_len_set,
    input  logic [BLOCK_W-1:0]        req_data,
    output logic                      pkt_valid,
    input  logic                      pkt_ready,
    output logic                      pkt_write,
    output logic [ADDR_W-BLK_LSB-1:0] pkt_addr,
    output logic [SEL_W-1:0]          pkt_sel,
    output logic [2:0]                pkt_len,
    output logic [LW_W-1:0]           pkt_data,
    input  logic                      rsp_valid,
    input  logic [LW_W-1:0]           rsp_data,
    output logic                      ret_valid,
    output logic [BLOCK_W-1:0]        ret_data,
    output logic                      err
);
    sp_state_e state, state_n;

    sp_len_e          len_w;
    logic             len_ok;
    logic [SEL_W-1:0] wr_sel;
    logic             mask_ok;
    logic [LW_W-1:0]  wr_lw;
    logic             req_ok;
    logic             take;

    logic                      write_q;
    logic [ADDR_W-BLK_LSB-1:0] addr_q;
    logic [SEL_W-1:0]          sel_q;
    sp_len_e                   len_q;
    logic [LW_W-1:0]           data_q;
    logic [LW_W-1:0]           rsp_q;
    logic                      err_q;
    logic [BLOCK_W-1:0]        aligned;

    sp_len_check i_len (
        .len_set (req_len_set),
        .offset  (req_addr[BLK_LSB +: 2]),
        .len     (len_w),
        .legal   (len_ok)
    );

    sp_lane_pick #(.LW_W(LW_W), .NLW(NLW)) i_pick (
        .mask    (req_mask),
        .data    (req_data),
        .sel     (wr_sel),
        .mask_ok (mask_ok),
        .lw      (wr_lw)
    );

    sp_ret_align #(.LW_W(LW_W), .NLW(NLW)) i_align (
        .sel  (sel_q),
        .word (rsp_q),
        .blk  (aligned)
    );

    assign req_ok = len_ok && (!req_write || mask_ok);
    assign take   = (state == S_IDLE) && req_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: if (req_valid && req_ok) state_n = S_SEND;
            S_SEND: if (pkt_ready) state_n = write_q ? S_IDLE : S_WAIT;
            S_WAIT: if (rsp_valid) state_n = S_RET;
            S_RET:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // Captured request and response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            sel_q   <= '0;
            len_q   <= LEN_BYTE;
            data_q  <= '0;
            rsp_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= take && !req_ok;
            if (take && req_ok) begin
                write_q <= req_write;
                addr_q  <= req_addr[ADDR_W-1:BLK_LSB];
                sel_q   <= req_write ? wr_sel : req_addr[PAIR_LSB +: SEL_W];
                len_q   <= len_w;
                data_q  <= req_write ? wr_lw : '0;
            end
            if (state == S_WAIT && rsp_valid) rsp_q <= rsp_data;
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state == S_IDLE);
        pkt_valid = (state == S_SEND);
        ret_valid = (state == S_RET);
        pkt_write = write_q;
        pkt_addr  = addr_q;
        pkt_sel   = sel_q;
        pkt_len   = len_q;
        pkt_data  = data_q;
        ret_data  = ret_valid ? aligned : '0;
        err       = err_q;
    end

    // R8: packet fields hold while stalled
    a_r8_pkt_stable: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data) && $stable(pkt_sel)
            && $stable(pkt_len) && $stable(pkt_addr) && $stable(pkt_write));

    // R8: no new request is taken while a packet is pending
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !req_ready);

    // R5: a refusal never comes with a packet
    a_r5_err_no_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !pkt_valid);

    // R3: an error pulse always follows an offered request
    a_r3_err_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_valid));

    // R7: return is a single-cycle pulse that follows a response
    a_r7_ret_single: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> !ret_valid);

    a_r7_ret_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(rsp_valid));
endmodule

// File: tb/test_sp_packetizer.sv
`timescale 1ns/1ps
module test_sp_packetizer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [31:3]  req_addr = '0;
    logic [7:0]   req_mask = '0;
    logic [4:0]   req_len_set = '0;
    logic [255:0] req_data = '0;
    logic         pkt_valid;
    logic         pkt_ready = 1'b0;
    logic         pkt_write;
    logic [26:0]  pkt_addr;
    logic [1:0]   pkt_sel;
    logic [2:0]   pkt_len;
    logic [31:0]  pkt_data;
    logic         rsp_valid = 1'b0;
    logic [31:0]  rsp_data = '0;
    logic         ret_valid;
    logic [255:0] ret_data;
    logic         err;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sp_packetizer i_sp_packetizer (.*);

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] blk(input logic [7:0] seed);
        logic [255:0] b;
        for (int i = 0; i < 8; i++) b[i*32 +: 32] = {seed, 8'hC0, 8'(i), 8'h5A ^ 8'(i)};
        return b;
    endfunction

    function automatic bit exp_legal(input int len, input int off);
        case (len)
            0: return 1'b1;
            1: return (off == 0) || (off == 2);
            2: return (off == 0) || (off == 1);
            3: return off == 0;
            4: return off == 3;
            default: return 1'b0;
        endcase
    endfunction

    // Offer one request for one edge; return at the negedge after it
    task automatic send(input bit wr, input logic [31:0] a, input logic [7:0] m,
                        input logic [4:0] ls, input logic [255:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a[31:3];
        req_mask = m; req_len_set = ls; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        pkt_ready = 1'b1;
        @(negedge clk);
        pkt_ready = 1'b0;
    endtask

    task automatic expect_refused(input string req);
        check(req, {254'd0, err, pkt_valid}, 256'b10);
        @(negedge clk);
        check(req, {254'd0, err, pkt_valid}, 256'b00);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #12;
        check("R1 during reset", {252'd0, req_ready, pkt_valid, ret_valid, err}, 256'b1000);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {252'd0, req_ready, pkt_valid, ret_valid, err}, 256'b1000);
    endtask

    task automatic t_write_lanes();
        for (int s = 0; s < 4; s++) begin
            logic [255:0] d = blk(8'(8'h10 + s));
            // lane bits in the address set opposite to the mask choice: R2 says ignored
            logic [31:0] a = 32'h1234_5000 | (32'(3 - s) << 3);
            send(1'b1, a, 8'(1 << (2 * s)), 5'b00001, d);
            check("R2 pkt_valid", 256'(pkt_valid), 256'd1);
            check("R2 pkt_write", 256'(pkt_write), 256'd1);
            check("R2 pkt_sel", 256'(pkt_sel), 256'(s));
            check("R2 pkt_data", 256'(pkt_data), 256'(d[(2*s)*32 +: 32]));
            check("R9 pkt_addr", 256'(pkt_addr), 256'(a[31:5]));
            check("R8 req_ready busy", 256'(req_ready), 256'd0);
            drain();
            check("R2 back idle", {254'd0, pkt_valid, req_ready}, 256'b01);
        end
    endtask

    task automatic t_mask_err();
        send(1'b1, 32'h0, 8'h05, 5'b00001, blk(8'h21)); expect_refused("R3 two lanes");
        send(1'b1, 32'h0, 8'h02, 5'b00001, blk(8'h22)); expect_refused("R3 odd lane");
        send(1'b1, 32'h0, 8'h00, 5'b00001, blk(8'h23)); expect_refused("R3 empty mask");
        send(1'b1, 32'h0, 8'h09, 5'b00001, blk(8'h24)); expect_refused("R3 even plus odd");
    endtask

    task automatic t_len_pick();
        send(1'b1, 32'h0, 8'h01, 5'b00011, blk(8'h31));
        check("R4 word over byte", 256'(pkt_len), 256'd1); drain();
        send(1'b1, 32'h0, 8'h01, 5'b01011, blk(8'h32));
        check("R4 longword largest", 256'(pkt_len), 256'd3); drain();
        send(1'b1, 32'h60, 8'h04, 5'b10001, blk(8'h33));
        check("R4 quad at 3", {253'd0, pkt_valid, pkt_len[1:0]}, {253'd0, 1'b1, 2'd0});
        check("R4 quad code", 256'(pkt_len), 256'd4); drain();
        send(1'b1, 32'h0, 8'h01, 5'b10001, blk(8'h34)); expect_refused("R4 quad wins then illegal");
        send(1'b1, 32'h0, 8'h01, 5'b00000, blk(8'h35)); expect_refused("R4 empty set");
    endtask

    task automatic t_legality();
        for (int l = 0; l < 5; l++) begin
            for (int o = 0; o < 4; o++) begin
                bit ok = exp_legal(l, o);
                send(1'b1, 32'(o) << 5, 8'h01, 5'(1 << l), blk(8'(l * 4 + o)));
                check($sformatf("R5 len%0d off%0d valid", l, o), 256'(pkt_valid), 256'(ok));
                check($sformatf("R5 len%0d off%0d err", l, o), 256'(err), 256'(!ok));
                if (ok) begin
                    check("R5 len code", 256'(pkt_len), 256'(l));
                    drain();
                end else begin
                    @(negedge clk);
                    check("R5 error one cycle", {254'd0, err, pkt_valid}, 256'b00);
                end
            end
        end
    endtask

    task automatic t_read();
        for (int s = 0; s < 4; s++) begin
            logic [31:0] a = 32'hABC0_0000 | (32'(s) << 3);
            logic [31:0] r = 32'hD00D_0000 + 32'(s);
            logic [255:0] e = '0;
            e[(2*s)*32 +: 32] = r;
            send(1'b0, a, 8'hFF, 5'b00001, blk(8'h77));
            check("R6 read valid", 256'(pkt_valid), 256'd1);
            check("R6 read dir", 256'(pkt_write), 256'd0);
            check("R6 read sel", 256'(pkt_sel), 256'(s));
            check("R6 read no data", 256'(pkt_data), 256'd0);
            drain();
            check("R7 waiting", {254'd0, req_ready, ret_valid}, 256'b00);
            rsp_valid = 1'b1; rsp_data = r;
            @(negedge clk);
            rsp_valid = 1'b0;
            check("R7 ret_valid", 256'(ret_valid), 256'd1);
            check("R7 ret_data lane", ret_data, e);
            @(negedge clk);
            check("R7 single pulse", {254'd0, ret_valid, req_ready}, 256'b01);
        end
    endtask

    task automatic t_stall();
        logic [255:0] d = blk(8'h99);
        send(1'b1, 32'h40, 8'h10, 5'b00001, d);
        // a second request offered while busy must be ignored
        req_valid = 1'b1; req_write = 1'b1; req_mask = 8'h01; req_data = blk(8'h55);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R8 stall valid", {254'd0, pkt_valid, req_ready}, 256'b10);
            check("R8 stall data", 256'(pkt_data), 256'(d[4*32 +: 32]));
            check("R8 stall sel", 256'(pkt_sel), 256'd2);
        end
        req_valid = 1'b0;
        drain();
        check("R8 busy request dropped", 256'(pkt_valid), 256'd0);
        @(negedge clk);
        check("R8 still idle", {254'd0, pkt_valid, req_ready}, 256'b01);
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_write_lanes();
        t_mask_err();
        t_len_pick();
        t_legality();
        t_read();
        t_stall();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule